// File: doc/BRIEF.md
# Calendar Alarm Matcher

This block holds four alarm registers (minute, hour, day of month, weekday) and compares them against the running calendar of a clock chip. The calendar counters live outside the block. They present their current values in BCD together with a single-cycle strobe that pulses once at each minute rollover. A comparison happens only on that strobe, so the alarm resolves to the minute and never looks at seconds.

Setting the top bit of an alarm register removes that field from the comparison. This gives repeating alarms: with only the minute enabled the alarm fires every hour, with minute and hour it fires every day, and with weekday added it fires every week. A hit sets a sticky flag in a control register. When the interrupt enable in the same register is also set, an active-low level interrupt is asserted and held until software writes 0 to the flag bit.

Top module: `cal_alarm`

## Requirements
- R1: After reset the four alarm registers read 0x80, which means every field is disabled. The control register reads 0x00 and `irq_n` is high.
- R2: The alarm registers sit at consecutive addresses starting at `ALM_BASE` (default 4), in the order minute, hour, day, weekday. A write to one of them is read back unchanged on `rd_data`. The control register is at `CTRL_ADDR` (default 0). Unmapped addresses read 0.
- R3: When bit 7 of an alarm register is 1, that field is left out of the compare. Each enabled field is compared on its low bits: minute uses 7 bits, hour 6, day 6 and weekday 3.
- R4: A match is evaluated only in a cycle where `min_tick` is 1. A matching time presented without the strobe does not set the flag.
- R5: When all four fields are disabled, the flag is never set.
- R6: The flag is bit 3 of the control register, and it stays set until a control write carries 0 in bit 3. A control write carrying 1 in bit 3 leaves the flag unchanged.
- R7: The interrupt enable is bit 1 of the control register. `irq_n` is low exactly when the flag and the enable are both 1, and it follows a change in either one in the cycle after the write.
- R8: If a match on the strobe and a control write that clears the flag occur in the same cycle, the flag ends up set.
- R9: A control write that changes only the enable bit, with 1 in bit 3, does not change the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| min_tick | input | 1 | One-cycle pulse at each minute rollover |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_day | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| irq_n | output | 1 | Active-low level alarm interrupt |

## Verification
Two events can land in the same cycle: the minute strobe raising the flag, and a software write clearing it. The bench provokes this by driving a matching time with the strobe in the same cycle as a control write of 0x02, both from an idle flag and from an already set flag. It judges the outcome by reading back the control register and sampling `irq_n`, and in both cases the flag must read as set. The rest of the function is covered by a sweep over all 16 field-enable masks, each crossed with all 16 patterns of mismatching fields; the expected hit is derived arithmetically from the mask and the pattern.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int NUM_FIELDS = 4;

   typedef enum logic [1:0] {
      FLD_MIN  = 2'd0,
      FLD_HOUR = 2'd1,
      FLD_DAY  = 2'd2,
      FLD_WDAY = 2'd3
   } field_e;

   // number of significant BCD bits compared per field
   function automatic int field_bits(input int idx);
      case (idx)
         0:       return 7;
         1:       return 6;
         2:       return 6;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int ALM_BASE  = 4,
   parameter int CTRL_ADDR = 0,
   parameter int IE_BIT    = 1,
   parameter int DIS_BIT   = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [NUM_FIELDS-1:0][DATA_W-1:0]    alm_q,
   output logic                                 ie_q
);
   localparam logic [DATA_W-1:0] ALM_RST = DATA_W'(1) << DIS_BIT;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_alm
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ALM_BASE + f);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            alm_q[f] <= ALM_RST;
         else if (wr_en && wr_addr == MY_ADDR)
            alm_q[f] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ie_q <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR))
         ie_q <= wr_data[IE_BIT];
   end

   assert_ie_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(ie_q));
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int DIS_BIT = 7
) (
   input  logic [NUM_FIELDS-1:0][DATA_W-1:0] alm,
   input  logic [NUM_FIELDS-1:0][DATA_W-1:0] cur,
   output logic                              all_match,
   output logic                              any_en
);
   logic [NUM_FIELDS-1:0] fld_ok;
   logic [NUM_FIELDS-1:0] fld_en;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      localparam int                NB   = field_bits(f);
      localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << NB) - 1);
      if (NB > DIS_BIT) begin : g_bad
         $error("field width overlaps the disable bit");
      end
      assign fld_en[f] = ~alm[f][DIS_BIT];
      assign fld_ok[f] = ~fld_en[f] | ((alm[f] & MASK) == (cur[f] & MASK));
   end

   assign all_match = &fld_ok;
   assign any_en    = |fld_en;
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag #(
   parameter int FLAG_BIT = 3,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              min_tick,
   input  logic              all_match,
   input  logic              any_en,
   input  logic              ctrl_wr,
   input  logic [DATA_W-1:0] ctrl_wdata,
   input  logic              ie,
   output logic              flag_q,
   output logic              irq_n
);
   logic hit;
   logic clr;

   assign hit = min_tick & all_match & any_en;
   assign clr = ctrl_wr & ~ctrl_wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (hit)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign irq_n = ~(flag_q & ie);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr |=> flag_q);
   assert_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q && !min_tick |=> !flag_q);
   assert_all_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q && !any_en |=> !flag_q);
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick && all_match && any_en && clr |=> flag_q);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 3,
   parameter int ALM_BASE  = 4,
   parameter int CTRL_ADDR = 0,
   parameter int FLAG_BIT  = 3,
   parameter int IE_BIT    = 1,
   parameter int DIS_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              min_tick,
   input  logic [6:0]        cur_min,
   input  logic [5:0]        cur_hour,
   input  logic [5:0]        cur_day,
   input  logic [2:0]        cur_wday,
   output logic              irq_n
);
   localparam int ALM_LAST = ALM_BASE + NUM_FIELDS - 1;

   if (DATA_W < 8 || DIS_BIT >= DATA_W) begin : g_chk_w
      $error("data width too small for the disable bit");
   end
   if (ALM_LAST >= (1 << ADDR_W)) begin : g_chk_a
      $error("alarm registers exceed address space");
   end
   if (CTRL_ADDR >= ALM_BASE && CTRL_ADDR <= ALM_LAST) begin : g_chk_c
      $error("control register overlaps alarm registers");
   end
   if (FLAG_BIT == IE_BIT || FLAG_BIT >= DATA_W || IE_BIT >= DATA_W) begin : g_chk_b
      $error("control bit positions invalid");
   end

   logic [NUM_FIELDS-1:0][DATA_W-1:0] alm_q;
   logic [NUM_FIELDS-1:0][DATA_W-1:0] cur_vec;
   logic ie_q, flag_q, all_match, any_en, ctrl_wr;

   assign cur_vec[FLD_MIN]  = DATA_W'(cur_min);
   assign cur_vec[FLD_HOUR] = DATA_W'(cur_hour);
   assign cur_vec[FLD_DAY]  = DATA_W'(cur_day);
   assign cur_vec[FLD_WDAY] = DATA_W'(cur_wday);
   assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

   cal_alarm_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ALM_BASE(ALM_BASE),
      .CTRL_ADDR(CTRL_ADDR), .IE_BIT(IE_BIT), .DIS_BIT(DIS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .alm_q(alm_q), .ie_q(ie_q)
   );

   cal_alarm_cmp #(.DATA_W(DATA_W), .DIS_BIT(DIS_BIT)) u_cmp (
      .alm(alm_q), .cur(cur_vec), .all_match(all_match), .any_en(any_en)
   );

   cal_alarm_flag #(.FLAG_BIT(FLAG_BIT), .DATA_W(DATA_W)) u_flag (
      .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .all_match(all_match),
      .any_en(any_en), .ctrl_wr(ctrl_wr), .ctrl_wdata(wr_data), .ie(ie_q),
      .flag_q(flag_q), .irq_n(irq_n)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
         rd_data[FLAG_BIT] = flag_q;
         rd_data[IE_BIT]   = ie_q;
      end
      for (int f = 0; f < NUM_FIELDS; f++)
         if (rd_addr == ADDR_W'(ALM_BASE + f))
            rd_data = alm_q[f];
   end

   assert_irq_needs_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (flag_q && ie_q));
endmodule

// File: tb/cal_alarm_tb.sv
module cal_alarm_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic min_tick = 1'b0;
   logic [6:0] cur_min = '0;
   logic [5:0] cur_hour = '0;
   logic [5:0] cur_day = '0;
   logic [2:0] cur_wday = '0;
   logic irq_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   cal_alarm u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .min_tick(min_tick), .cur_min(cur_min), .cur_hour(cur_hour),
      .cur_day(cur_day), .cur_wday(cur_wday), .irq_n(irq_n)
   );

   localparam logic [7:0] AV [4] = '{8'h45, 8'h13, 8'h28, 8'h05};

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic set_time(input logic [3:0] diff);
      cur_min  = 7'(AV[0] + (diff[0] ? 8'd1 : 8'd0));
      cur_hour = 6'(AV[1] + (diff[1] ? 8'd1 : 8'd0));
      cur_day  = 6'(AV[2] + (diff[2] ? 8'd1 : 8'd0));
      cur_wday = 3'(AV[3] + (diff[3] ? 8'd1 : 8'd0));
   endtask

   // strobe one minute, optionally with a control write in the same cycle
   task automatic tick(input logic [3:0] diff, input bit with_wr, input logic [7:0] d);
      @(negedge clk);
      set_time(diff);
      min_tick = 1'b1;
      if (with_wr) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = d; end
      @(negedge clk);
      min_tick = 1'b0; wr_en = 1'b0;
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
      for (int i = 0; i < 4; i++) begin rd(3'(4 + i), v); chk("R1 alarm", v, 8'h80); end
      // R2 readback, unmapped reads
      for (int i = 0; i < 4; i++) wr(3'(4 + i), 8'h31 + 8'(i * 17));
      for (int i = 0; i < 4; i++) begin rd(3'(4 + i), v); chk("R2 readback", v, 8'h31 + 8'(i * 17)); end
      for (int i = 1; i < 4; i++) begin rd(3'(i), v); chk("R2 unmapped", v, 8'h00); end

      // R3/R5 sweep: enable mask x mismatch pattern
      for (int m = 0; m < 16; m++) begin
         for (int i = 0; i < 4; i++) wr(3'(4 + i), AV[i] | (m[i] ? 8'h00 : 8'h80));
         wr(3'd0, 8'h02);
         for (int d = 0; d < 16; d++) begin
            bit exp;
            exp = (m != 0) && ((d & m) == 0);
            tick(4'(d), 1'b0, 8'h00);
            chk(m == 0 ? "R5 all disabled" : "R3 field compare",
                {7'd0, irq_n}, {7'd0, ~exp});
            wr(3'd0, 8'h02);
         end
      end

      // alarm fully enabled from here
      for (int i = 0; i < 4; i++) wr(3'(4 + i), AV[i]);
      wr(3'd0, 8'h02);
      // R4 matching time without strobe
      @(negedge clk); set_time(4'd0);
      repeat (5) @(negedge clk);
      rd(3'd0, v); chk("R4 no strobe", v, 8'h02);
      chk("R4 irq_n", {7'd0, irq_n}, 8'h01);
      // R6 sticky, write-one ignored
      tick(4'd0, 1'b0, 8'h00);
      tick(4'hF, 1'b0, 8'h00);
      repeat (4) @(negedge clk);
      rd(3'd0, v); chk("R6 sticky", v, 8'h0A);
      wr(3'd0, 8'h0A);
      rd(3'd0, v); chk("R6 write one", v, 8'h0A);
      // R7/R9 enable toggles with flag bit written as 1
      wr(3'd0, 8'h08);
      rd(3'd0, v); chk("R9 flag kept", v, 8'h08);
      chk("R7 irq off", {7'd0, irq_n}, 8'h01);
      wr(3'd0, 8'h0A);
      chk("R7 irq on", {7'd0, irq_n}, 8'h00);
      wr(3'd0, 8'h02);
      rd(3'd0, v); chk("R6 clear", v, 8'h02);
      chk("R7 irq released", {7'd0, irq_n}, 8'h01);
      // R8 set and clear in the same cycle, from idle and from set
      tick(4'd0, 1'b1, 8'h02);
      rd(3'd0, v); chk("R8 idle", v, 8'h0A);
      tick(4'd0, 1'b1, 8'h02);
      rd(3'd0, v); chk("R8 set", v, 8'h0A);
      chk("R8 irq", {7'd0, irq_n}, 8'h00);
      // clear with non-matching strobe in same cycle
      tick(4'd1, 1'b1, 8'h02);
      rd(3'd0, v); chk("R6 clear with miss", v, 8'h02);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule